// File: doc/BRIEF.md
# Narrow ROM Boot Image Copier

This block moves a boot image out of a byte-wide or half-word-wide external ROM into the processor's memory before the processor is allowed to run. A single start pulse begins one block transfer of a fixed 1024-byte image. The source is the first byte of the ROM's chip-select region (`ROM_BASE`). The destination begins at address 0 (`DST_BASE`). The block raises a sticky done level once the last word has landed. Release logic elsewhere uses that level to let the processor leave its stalled state.

ROM reads go through a request/acknowledge port that delivers 8 or 16 bits per beat. The block gathers two half-words or four bytes into one 32-bit word and places them by the configured endianness. It then presents the word on a valid/ready write port. At most one word is held at a time. Reads stop while a word waits to be written, so the two ports never carry traffic in the same cycle.

Top module: `boot_rom_copier`

## Requirements
- R1: During reset and after it, until a start is taken, `rom_req_o`, `dst_valid_o`, `busy_o` and `done_o` are all 0.
- R2: A 1 on `start_i` is taken only while the block is idle and has not yet finished. In the next cycle `busy_o` and `rom_req_o` are 1. A start pulse during a copy or after done has no effect.
- R3: `wide_i` (1 = 16-bit ROM, 0 = 8-bit ROM) and `big_i` (1 = big-endian, 0 = little-endian) are captured when start is taken. Changing them during a copy does not change the copy.
- R4: A read request keeps `rom_addr_o` steady until `rom_ack_i` is seen. The first read is at `ROM_BASE`. Each acknowledged beat advances the source by 1 (8-bit) or 2 (16-bit), so the whole copy covers exactly 1024 source bytes.
- R5: In 8-bit mode only `rom_data_i[7:0]` is used. With little-endian order the four bytes of a word fill bits [7:0], [15:8], [23:16], [31:24] in read order. With big-endian order they fill [31:24], [23:16], [15:8], [7:0].
- R6: In 16-bit mode `rom_data_i[15:0]` is taken whole. The first half-word goes to bits [15:0] for little-endian and to bits [31:16] for big-endian. The second goes to the other half.
- R7: Exactly 256 words are written. The first goes to `DST_BASE` and the address rises by 4 after each accepted write. While `dst_valid_o` is 1 and `dst_ready_i` is 0, the address and data hold.
- R8: `rom_req_o` and `dst_valid_o` are never 1 in the same cycle.
- R9: `done_o` rises in the cycle after the 256th write is accepted and stays 1 until reset. From then on there are no reads or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for the copy |
| wide_i | input | 1 | ROM width select: 1 = 16-bit, 0 = 8-bit |
| big_i | input | 1 | Packing order: 1 = big-endian, 0 = little-endian |
| rom_req_o | output | 1 | ROM read request |
| rom_addr_o | output | ADDR_W | ROM byte address of the current read |
| rom_ack_i | input | 1 | ROM read acknowledge, data valid this cycle |
| rom_data_i | input | 16 | ROM read data (8-bit mode uses [7:0]) |
| dst_valid_o | output | 1 | Destination write valid |
| dst_addr_o | output | ADDR_W | Destination byte address |
| dst_data_o | output | 32 | Assembled 32-bit word |
| dst_ready_i | input | 1 | Destination accepts the write this cycle |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | Sticky copy-complete level |

## Verification
The copy is run in all four combinations of width and endianness. The ROM holds a position-dependent byte pattern, so a swapped byte, a swapped half-word or a skipped beat each produce a word that differs from the one the bench computes from the image. In 8-bit mode the ROM drives noise on the upper data byte, which exposes any use of those bits. Acknowledge and ready arrive after pseudo-random delays, which tests the address hold and the write hold. Two further runs flip the width and order inputs and pulse start part-way through a copy. These show whether the configuration is captured at start and whether a late start pulse restarts the copy.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } bcp_state_e;

  // Bytes consumed from the ROM per acknowledged beat.
  function automatic logic [1:0] src_step(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

  // Index of the final beat inside one 32-bit word.
  function automatic logic [1:0] last_beat_idx(input logic wide);
    return wide ? 2'd1 : 2'd3;
  endfunction

  // Place beat number idx into the word under assembly.
  function automatic logic [31:0] merge_beat(input logic [31:0] acc,
                                             input logic [15:0] beat,
                                             input logic [1:0]  idx,
                                             input logic        wide,
                                             input logic        big);
    logic [31:0] r;
    logic [1:0]  slot;
    logic        upper;
    r = acc;
    if (wide) begin
      upper = idx[0] ^ big;
      if (upper) r[31:16] = beat;
      else       r[15:0]  = beat;
    end else begin
      slot = big ? (2'd3 - idx) : idx;
      r[{slot, 3'b000} +: 8] = beat[7:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/bcp_ctrl.sv
module bcp_ctrl
  import bcp_pkg::*;
#(
  parameter int WORDS = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_accept,
  input  logic       beat_fire,
  input  logic       wr_fire,
  input  logic       wide_i,
  input  logic       big_i,
  output bcp_state_e state,
  output logic       cfg_wide,
  output logic       cfg_big,
  output logic [1:0] beat_idx,
  output logic       last_beat,
  output logic       last_word
);
  localparam int WCNT_W = $clog2(WORDS) + 1;

  logic [WCNT_W-1:0] wcnt;

  assign last_beat = (beat_idx == last_beat_idx(cfg_wide));
  assign last_word = (wcnt == WCNT_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cfg_wide <= 1'b0;
      cfg_big  <= 1'b0;
      beat_idx <= '0;
      wcnt     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_accept) begin
            state    <= ST_READ;
            cfg_wide <= wide_i;
            cfg_big  <= big_i;
            beat_idx <= '0;
            wcnt     <= '0;
          end
        end
        ST_READ: begin
          if (beat_fire) begin
            if (last_beat) begin
              state    <= ST_WRITE;
              beat_idx <= '0;
            end else begin
              beat_idx <= beat_idx + 2'd1;
            end
          end
        end
        ST_WRITE: begin
          if (wr_fire) begin
            wcnt  <= wcnt + 1'b1;
            state <= last_word ? ST_DONE : ST_READ;
          end
        end
        ST_DONE: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bcp_addr_gen.sv
module bcp_addr_gen
  import bcp_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] ROM_BASE = 32'h9000_0000,
  parameter logic [ADDR_W-1:0] DST_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_accept,
  input  logic              beat_fire,
  input  logic              wr_fire,
  input  logic              cfg_wide,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr
);
  localparam logic [ADDR_W-1:0] DST_STEP = ADDR_W'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_addr <= ROM_BASE;
      dst_addr <= DST_BASE;
    end else begin
      if (start_accept) begin
        src_addr <= ROM_BASE;
        dst_addr <= DST_BASE;
      end else begin
        if (beat_fire) src_addr <= src_addr + ADDR_W'(src_step(cfg_wide));
        if (wr_fire)   dst_addr <= dst_addr + DST_STEP;
      end
    end
  end
endmodule

// File: rtl/bcp_packer.sv
module bcp_packer
  import bcp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat_fire,
  input  logic [15:0] beat_data,
  input  logic [1:0]  beat_idx,
  input  logic        cfg_wide,
  input  logic        cfg_big,
  output logic [31:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
    end else if (beat_fire) begin
      word <= merge_beat(word, beat_data, beat_idx, cfg_wide, cfg_big);
    end
  end
endmodule

// File: rtl/boot_rom_copier.sv
module boot_rom_copier
  import bcp_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] ROM_BASE    = 32'h9000_0000,
  parameter logic [ADDR_W-1:0] DST_BASE    = '0,
  parameter int                IMAGE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wide_i,
  input  logic              big_i,
  output logic              rom_req_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic              rom_ack_i,
  input  logic [15:0]       rom_data_i,
  output logic              dst_valid_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [31:0]       dst_data_o,
  input  logic              dst_ready_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int WORDS = IMAGE_BYTES / 4;

  bcp_state_e  state;
  logic        cfg_wide, cfg_big;
  logic [1:0]  beat_idx;
  logic        last_beat, last_word;

  // Named internal events, also observed by the bound checker.
  logic start_accept, beat_fire, wr_fire;
  assign start_accept = start_i && (state == ST_IDLE);
  assign beat_fire    = rom_ack_i && (state == ST_READ);
  assign wr_fire      = dst_ready_i && (state == ST_WRITE);

  bcp_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_accept(start_accept), .beat_fire(beat_fire), .wr_fire(wr_fire),
    .wide_i(wide_i), .big_i(big_i),
    .state(state), .cfg_wide(cfg_wide), .cfg_big(cfg_big),
    .beat_idx(beat_idx), .last_beat(last_beat), .last_word(last_word)
  );

  bcp_addr_gen #(.ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .DST_BASE(DST_BASE)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .start_accept(start_accept), .beat_fire(beat_fire), .wr_fire(wr_fire),
    .cfg_wide(cfg_wide), .src_addr(rom_addr_o), .dst_addr(dst_addr_o)
  );

  bcp_packer u_pack (
    .clk(clk), .rst_n(rst_n),
    .beat_fire(beat_fire), .beat_data(rom_data_i), .beat_idx(beat_idx),
    .cfg_wide(cfg_wide), .cfg_big(cfg_big), .word(dst_data_o)
  );

  assign rom_req_o   = (state == ST_READ);
  assign dst_valid_o = (state == ST_WRITE);
  assign busy_o      = (state == ST_READ) || (state == ST_WRITE);
  assign done_o      = (state == ST_DONE);
endmodule

// File: rtl/bcp_checker.sv
module bcp_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rom_req,
  input logic              rom_ack,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              dst_valid,
  input logic              dst_ready,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [31:0]       dst_data,
  input logic              busy,
  input logic              done,
  input logic              beat_fire,
  input logic              wr_fire,
  input logic              cfg_wide
);
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req && !rom_ack |=> rom_req && $stable(rom_addr));

  a_r4_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> !rom_req ||
      (rom_addr == $past(rom_addr) + (cfg_wide ? ADDR_W'(2) : ADDR_W'(1))));

  a_r7_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !dst_ready |=> dst_valid && $stable(dst_addr) && $stable(dst_data));

  a_r7_dst_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> dst_addr[1:0] == 2'b00);

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_req && dst_valid));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rom_req && !dst_valid && !busy);

  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_fire));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rom_req && !dst_valid);
endmodule

bind boot_rom_copier bcp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rom_req(rom_req_o), .rom_ack(rom_ack_i), .rom_addr(rom_addr_o),
  .dst_valid(dst_valid_o), .dst_ready(dst_ready_i), .dst_addr(dst_addr_o),
  .dst_data(dst_data_o), .busy(busy_o), .done(done_o),
  .beat_fire(beat_fire), .wr_fire(wr_fire), .cfg_wide(cfg_wide)
);

// File: tb/boot_rom_copier_test.sv
module boot_rom_copier_test;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] ROM_BASE   = 32'h9000_0000;
  localparam int          BYTES      = 1024;
  localparam int          WORDS      = BYTES / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, wide_i = 1'b0, big_i = 1'b0;
  logic        rom_ack_i = 1'b0, dst_ready_i = 1'b0;
  logic [15:0] rom_data_i = '0;
  logic        rom_req_o, dst_valid_o, busy_o, done_o;
  logic [31:0] rom_addr_o, dst_addr_o, dst_data_o;

  int          checks = 0, errors = 0;
  int          exp_src = 0, wr_count = 0, post_done_traffic = 0;
  logic        run_wide = 1'b0, run_big = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit          finished = 0;

  boot_rom_copier #(.ROM_BASE(ROM_BASE)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i), .big_i(big_i),
    .rom_req_o(rom_req_o), .rom_addr_o(rom_addr_o), .rom_ack_i(rom_ack_i),
    .rom_data_i(rom_data_i), .dst_valid_o(dst_valid_o), .dst_addr_o(dst_addr_o),
    .dst_data_o(dst_data_o), .dst_ready_i(dst_ready_i), .busy_o(busy_o), .done_o(done_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] img(input int i);
    return 8'((i * 29) ^ (i >> 2) ^ 8'h5B);
  endfunction

  // The word as the image reads in memory under the chosen byte order.
  function automatic logic [31:0] ref_word(input int k, input logic big);
    logic [7:0] b0, b1, b2, b3;
    b0 = img(4 * k); b1 = img(4 * k + 1); b2 = img(4 * k + 2); b3 = img(4 * k + 3);
    return big ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
  endfunction

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model, ROM and sink: compared on every falling edge.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) begin
      rom_ack_i   = 1'b0;
      dst_ready_i = 1'b0;
    end else begin
      check_eq("R9", "done level", 32'(done_o), 32'(wr_count == WORDS));
      check_eq("R8", "read/write overlap", 32'(rom_req_o & dst_valid_o), 32'd0);
      if (done_o && (rom_req_o || dst_valid_o)) post_done_traffic++;
      if (rom_req_o && lfsr[0]) begin
        check_eq("R4", "read address", rom_addr_o, ROM_BASE + 32'(exp_src));
        if (run_wide)
          rom_data_i = run_big ? {img(exp_src), img(exp_src + 1)}
                               : {img(exp_src + 1), img(exp_src)};
        else
          rom_data_i = {8'hC3 ^ lfsr[15:8], img(exp_src)};
        rom_ack_i = 1'b1;
        exp_src += run_wide ? 2 : 1;
      end else begin
        rom_ack_i  = 1'b0;
        rom_data_i = lfsr;
      end
      dst_ready_i = lfsr[3] | lfsr[6];
      if (dst_valid_o && dst_ready_i) begin
        check_eq("R7", "write address", dst_addr_o, 32'(wr_count * 4));
        check_eq(run_wide ? "R6" : "R5", "write data", dst_data_o, ref_word(wr_count, run_big));
        wr_count++;
      end
    end
  end

  task automatic run_copy(input logic wide, input logic big, input bit disturb);
    @(negedge clk);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1", "req in reset", 32'(rom_req_o), 32'd0);
    check_eq("R1", "valid/busy/done in reset", {29'd0, dst_valid_o, busy_o, done_o}, 32'd0);
    #1;
    wide_i = wide; big_i = big; run_wide = wide; run_big = big;
    exp_src = 0; wr_count = 0; post_done_traffic = 0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R1", "idle after reset", {28'd0, rom_req_o, dst_valid_o, busy_o, done_o}, 32'd0);
    #1 start_i = 1'b1;
    @(negedge clk);
    check_eq("R2", "busy after start", 32'(busy_o), 32'd1);
    check_eq("R2", "read after start", 32'(rom_req_o), 32'd1);
    #1 start_i = 1'b0;
    if (disturb) begin
      while (wr_count < 10) @(negedge clk);
      #1;
      wide_i = ~wide; big_i = ~big;  // R3: must not alter the running copy
      start_i = 1'b1;                // R2: ignored mid-copy
      @(negedge clk);
      #1 start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    check_eq("R7", "words written", 32'(wr_count), 32'(WORDS));
    check_eq(disturb ? "R3" : "R4", "source bytes consumed", 32'(exp_src), 32'(BYTES));
    #1 start_i = 1'b1;
    @(negedge clk);
    #1 start_i = 1'b0;
    repeat (20) @(negedge clk);
    check_eq("R9", "done held", 32'(done_o), 32'd1);
    check_eq("R9", "traffic after done", 32'(post_done_traffic), 32'd0);
    check_eq("R2", "start after done ignored", 32'(busy_o), 32'd0);
  endtask

  initial begin
    run_copy(1'b0, 1'b0, 1'b0);
    run_copy(1'b0, 1'b1, 1'b0);
    run_copy(1'b1, 1'b0, 1'b0);
    run_copy(1'b1, 1'b1, 1'b0);
    run_copy(1'b0, 1'b1, 1'b1);
    run_copy(1'b1, 1'b0, 1'b1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule